// File: doc/BRIEF.md
# I2C Master Read Controller

This block is an I2C bus master that fetches a programmed number of bytes from one addressed slave. Software loads a byte count, an SCL divider and a target byte holding the 7-bit slave address and the direction bit. Writing the target byte with the read bit set starts the transfer. The block then issues a start condition, shifts out the address byte and checks the slave's acknowledge. It clocks in data bytes, acknowledging all but the last, and closes with a stop condition. Both bus wires are open drain. The block only pulls them low through output enables and reads SDA back through `sda_in`.

Received bytes go into a two-entry FIFO. While that FIFO holds data, a ready status bit and the interrupt line stay high, and each read of the data register pops one entry. The master answers with NACK and then stops in two cases: when the FIFO is full at the acknowledge slot, or when the count is used up. If the target byte is written again during a transfer, the internal counter reloads from the count register, so a transfer can run past eight bytes.

The control state machine has these states. IDLE has both wires released. START holds SDA low while SCL is high. ADDR shifts out the eight address bits. ADDR_ACK samples the slave's acknowledge. RX shifts in eight data bits. RX_ACK drives ACK or NACK. STOP_LO, STOP_HI and STOP_END form the stop condition. The transitions are:
- IDLE to START on a go write.
- START to ADDR after one high period.
- ADDR to ADDR_ACK after bit 0.
- ADDR_ACK to RX if the slave acknowledged, or to STOP_LO if it did not.
- RX to RX_ACK after bit 0.
- RX_ACK to RX after an ACK, or to STOP_LO after a NACK.
- STOP_LO to STOP_HI, then STOP_HI to STOP_END, then STOP_END back to IDLE, each after one SCL phase.

Top module: `i2c_rd_master`

## Requirements
- R1: After reset, SCL and SDA are released (`scl_oe`=0, `sda_oe`=0), the status register reads 0 and `irq` is low.
- R2: Writing register 1 (the target byte: bits 7:1 address, bit 0 direction) with bit 0 = 1 while idle starts a transfer. SDA falls while SCL is high, then the address byte goes out MSB first, ending with direction bit 1.
- R3: A transfer receives count+1 bytes, where count is bits 2:0 of register 0. The master ACKs every byte except the last, NACKs the last one, and then generates a stop condition (SDA rises while SCL is high).
- R4: Bits 7:0 of register 2 set the number of system clocks SCL stays low, and bits 15:8 set the number it stays high. A field value of 0 acts as 1.
- R5: Outside start and stop conditions, SDA changes only while SCL is low. Data is sampled as SCL is released, MSB first.
- R6: When the ninth clock of a stored byte completes, status bit 3 sets and `irq` rises. Both stay set while the FIFO is non-empty. Only a read of register 3 clears them, and each such read returns the oldest byte in bits 7:0 and pops it.
- R7: The FIFO holds two bytes. A byte arriving while it is full is answered with NACK and discarded. Status bit 2 then sets and the master generates a stop.
- R8: If the address byte is not acknowledged, status bit 1 sets and the master stops and returns to idle without clocking in any data.
- R9: Writing register 1 during a transfer reloads the internal byte counter from register 0 without a new start condition.
- R10: Writing register 1 with bit 0 = 0 while idle starts nothing, and both bus wires stay released.
- R11: Status bit 0 is high from the cycle after the go write until the stop condition has completed. Status bits 1 and 2 clear when a new transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO on register 3) |
| reg_addr | input | 3 | Register index: 0 count, 1 target, 2 divider, 3 data, 4 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |
| irq | output | 1 | High while received data waits in the FIFO |

## Verification
The checker watches several rules on every clock:
- within a bit state, SDA holds steady while SCL is released;
- no byte is written into a full FIFO;
- `irq` rises only on a store and falls only on a data-register read;
- a go write always leads into START;
- a refused address always leads straight into the stop sequence.

Other behaviour shows only in the bench scenarios, against a behavioural slave that decodes the wires:
- byte counts and the ACK/NACK pattern;
- SCL high and low widths;
- the counter reload;
- the drop on a full FIFO;
- a refused address;
- a target write that is ignored.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    localparam int BYTE_W    = 8;
    localparam int REG_AW    = 3;

    localparam logic [REG_AW-1:0] OFS_COUNT  = 3'd0;
    localparam logic [REG_AW-1:0] OFS_TARGET = 3'd1;
    localparam logic [REG_AW-1:0] OFS_DIV    = 3'd2;
    localparam logic [REG_AW-1:0] OFS_RXDATA = 3'd3;
    localparam logic [REG_AW-1:0] OFS_STATUS = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_ADDR_ACK,
        S_RX,
        S_RX_ACK,
        S_STOP_LO,
        S_STOP_HI,
        S_STOP_END
    } rd_state_t;

endpackage

// File: rtl/i2c_rd_tmr.sv
module i2c_rd_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         tick
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (len == '0) ? '0 : len - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign tick = (cnt == '0);

endmodule

// File: rtl/i2c_rd_fifo.sv
module i2c_rd_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            end
            if (do_pop) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
    import i2c_rd_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              reload,
    input  logic [CNT_W-1:0]  count_val,
    input  logic [BYTE_W-1:0] target,
    input  logic [DIV_W-1:0]  len_hi,
    input  logic [DIV_W-1:0]  len_lo,
    input  logic              tick,
    input  logic              sda_in,
    input  logic              fifo_full,
    output logic              tmr_load,
    output logic [DIV_W-1:0]  tmr_len,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              drop_evt,
    output logic              nack_evt,
    output rd_state_t         state,
    output logic              half_o
);

    localparam int BIT_W = $clog2(BYTE_W);

    rd_state_t          st, st_n;
    logic               half, half_n;
    logic [BIT_W-1:0]   bitn;
    logic [BYTE_W-1:0]  shreg;
    logic [CNT_W-1:0]   remain;
    logic               ack_smp;
    logic               give_ack;
    logic               full_at_ack;
    logic               end_lo, end_hi;

    assign end_lo = tick && !half;
    assign end_hi = tick && half;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            half <= 1'b0;
        end else begin
            st   <= st_n;
            half <= half_n;
        end
    end

    // next state and phase timer loading
    always_comb begin
        st_n     = st;
        half_n   = half;
        tmr_load = 1'b0;
        tmr_len  = len_hi;
        unique case (st)
            S_IDLE: begin
                if (go) begin
                    st_n     = S_START;
                    half_n   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_len  = len_hi;
                end
            end
            S_START: begin
                if (tick) begin
                    st_n     = S_ADDR;
                    half_n   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_len  = len_lo;
                end
            end
            S_ADDR, S_RX: begin
                if (end_lo) begin
                    half_n   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_len  = len_hi;
                end else if (end_hi) begin
                    half_n   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_len  = len_lo;
                    if (bitn == '0) begin
                        st_n = (st == S_ADDR) ? S_ADDR_ACK : S_RX_ACK;
                    end
                end
            end
            S_ADDR_ACK: begin
                if (end_lo) begin
                    half_n   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_len  = len_hi;
                end else if (end_hi) begin
                    half_n   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_len  = len_lo;
                    st_n     = ack_smp ? S_STOP_LO : S_RX;
                end
            end
            S_RX_ACK: begin
                if (end_lo) begin
                    half_n   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_len  = len_hi;
                end else if (end_hi) begin
                    half_n   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_len  = len_lo;
                    st_n     = give_ack ? S_RX : S_STOP_LO;
                end
            end
            S_STOP_LO: begin
                if (tick) begin
                    st_n     = S_STOP_HI;
                    tmr_load = 1'b1;
                    tmr_len  = len_hi;
                end
            end
            S_STOP_HI: begin
                if (tick) begin
                    st_n     = S_STOP_END;
                    tmr_load = 1'b1;
                    tmr_len  = len_hi;
                end
            end
            S_STOP_END: begin
                if (tick) begin
                    st_n = S_IDLE;
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    // bus drive and event outputs
    always_comb begin
        scl_oe   = 1'b0;
        sda_oe   = 1'b0;
        push     = 1'b0;
        drop_evt = 1'b0;
        nack_evt = 1'b0;
        unique case (st)
            S_IDLE:     ;
            S_START:    sda_oe = 1'b1;
            S_ADDR: begin
                scl_oe = !half;
                sda_oe = !shreg[BYTE_W-1];
            end
            S_ADDR_ACK: begin
                scl_oe   = !half;
                nack_evt = end_hi && ack_smp;
            end
            S_RX:       scl_oe = !half;
            S_RX_ACK: begin
                scl_oe   = !half;
                sda_oe   = give_ack;
                push     = end_hi && !full_at_ack;
                drop_evt = end_hi && full_at_ack;
            end
            S_STOP_LO: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            S_STOP_HI:  sda_oe = 1'b1;
            S_STOP_END: ;
            default:    ;
        endcase
    end

    // shift register, bit index, acknowledge decision, byte counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            bitn        <= '0;
            ack_smp     <= 1'b0;
            give_ack    <= 1'b0;
            full_at_ack <= 1'b0;
            remain      <= '0;
        end else begin
            if (st == S_IDLE && go) begin
                shreg <= target;
                bitn  <= '1;
            end
            if (st == S_ADDR && end_hi) begin
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                bitn  <= bitn - BIT_W'(1);
            end
            if (st == S_ADDR_ACK && end_lo) begin
                ack_smp <= sda_in;
            end
            if (st == S_RX && end_lo) begin
                shreg <= {shreg[BYTE_W-2:0], sda_in};
            end
            if (st == S_RX && end_hi) begin
                bitn <= bitn - BIT_W'(1);
                if (bitn == '0) begin
                    give_ack    <= (remain != '0) && !fifo_full;
                    full_at_ack <= fifo_full;
                end
            end
            if (st == S_IDLE && go) begin
                remain <= count_val;
            end else if (reload) begin
                remain <= count_val;
            end else if (st == S_RX_ACK && end_hi && give_ack) begin
                remain <= remain - CNT_W'(1);
            end
        end
    end

    assign rx_byte = shreg;
    assign state   = st;
    assign half_o  = half;

endmodule

// File: rtl/i2c_rd_master.sv
module i2c_rd_master
    import i2c_rd_pkg::*;
#(
    parameter int          CNT_W      = 3,
    parameter int          DIV_W      = 8,
    parameter int          FIFO_DEPTH = 2,
    parameter logic [15:0] DIV_RESET  = 16'hCFCF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_in,
    output logic        irq
);

    localparam int REG_W = 2 * DIV_W;

    logic [CNT_W-1:0]  count_q;
    logic [BYTE_W-1:0] target_q;
    logic [REG_W-1:0]  div_q;
    logic              flag_nack, flag_drop;

    logic              wr_count, wr_target, wr_div;
    logic              go, reload, pop;

    rd_state_t         st;
    logic              half;
    logic              tick, tmr_load;
    logic [DIV_W-1:0]  tmr_len;
    logic              push, drop_evt, nack_evt;
    logic [BYTE_W-1:0] rx_byte, fifo_dout;
    logic              fifo_full, fifo_empty;

    assign wr_count  = reg_wr && (reg_addr == OFS_COUNT);
    assign wr_target = reg_wr && (reg_addr == OFS_TARGET);
    assign wr_div    = reg_wr && (reg_addr == OFS_DIV);
    assign go        = wr_target && reg_wdata[0] && (st == S_IDLE);
    assign reload    = wr_target && (st != S_IDLE);
    assign pop       = reg_rd && (reg_addr == OFS_RXDATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            target_q  <= '0;
            div_q     <= REG_W'(DIV_RESET);
            flag_nack <= 1'b0;
            flag_drop <= 1'b0;
        end else begin
            if (wr_count)  count_q  <= reg_wdata[CNT_W-1:0];
            if (wr_target) target_q <= reg_wdata[BYTE_W-1:0];
            if (wr_div)    div_q    <= reg_wdata[REG_W-1:0];
            if (go) begin
                flag_nack <= 1'b0;
                flag_drop <= 1'b0;
            end else begin
                if (nack_evt) flag_nack <= 1'b1;
                if (drop_evt) flag_drop <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_COUNT:  reg_rdata = 16'(count_q);
            OFS_TARGET: reg_rdata = 16'(target_q);
            OFS_DIV:    reg_rdata = 16'(div_q);
            OFS_RXDATA: reg_rdata = fifo_empty ? '0 : 16'(fifo_dout);
            OFS_STATUS: reg_rdata = {12'd0, !fifo_empty, flag_drop, flag_nack, (st != S_IDLE)};
            default:    reg_rdata = '0;
        endcase
    end

    i2c_rd_tmr #(.W(DIV_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .tick  (tick)
    );

    i2c_rd_fsm #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .reload    (reload),
        .count_val (count_q),
        .target    (wr_target ? reg_wdata[BYTE_W-1:0] : target_q),
        .len_hi    (div_q[REG_W-1:DIV_W]),
        .len_lo    (div_q[DIV_W-1:0]),
        .tick      (tick),
        .sda_in    (sda_in),
        .fifo_full (fifo_full),
        .tmr_load  (tmr_load),
        .tmr_len   (tmr_len),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .push      (push),
        .rx_byte   (rx_byte),
        .drop_evt  (drop_evt),
        .nack_evt  (nack_evt),
        .state     (st),
        .half_o    (half)
    );

    i2c_rd_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (rx_byte),
        .pop   (pop),
        .dout  (fifo_dout),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    assign irq = !fifo_empty;

endmodule

// File: rtl/i2c_rd_master_chk.sv
module i2c_rd_master_chk
    import i2c_rd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input rd_state_t st,
    input logic      scl_oe,
    input logic      sda_oe,
    input logic      push,
    input logic      pop,
    input logic      fifo_full,
    input logic      irq,
    input logic      flag_nack,
    input logic      go
);

    // R5
    sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st inside {S_ADDR, S_ADDR_ACK, S_RX, S_RX_ACK}) && (st == $past(st))
         && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !fifo_full);

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(push));

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(pop));

    // R2
    go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (st == S_START));

    // R8
    nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_nack) |-> (st == S_STOP_LO));

endmodule

bind i2c_rd_master i2c_rd_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .push      (push),
    .pop       (pop),
    .fifo_full (fifo_full),
    .irq       (irq),
    .flag_nack (flag_nack),
    .go        (go)
);

// File: tb/i2c_rd_master_test.sv
`timescale 1ns/1ps
module i2c_rd_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        scl_oe, sda_oe, sda_in, irq;
    logic        slv_drv = 1'b0;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign sda_in = !(sda_oe || slv_drv);

    i2c_rd_master uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in), .irq(irq)
    );

    // behavioural slave and bus monitor
    logic [6:0] slave_addr = 7'h50;
    logic [7:0] addr_seen, s_sh, s_cur;
    int  s_mode, s_bits, s_idx, sent, starts, stops, irq_rises, terr;
    int  run, exp_lo, exp_hi;
    bit  acks[$];
    bit  p_scl = 1, p_sda = 1, p_irq = 0, lvl = 1, seen_low = 0, active = 0, any_oe = 0;
    logic [7:0] got[$];

    function automatic logic [7:0] pattern(int i);
        return 8'(60 + i * 23);
    endfunction

    always @(negedge clk) begin
        bit scl_n, sda_n;
        if (rst_n) begin
            scl_n = !scl_oe;
            sda_n = !(sda_oe || slv_drv);
            if (scl_oe || sda_oe) any_oe = 1;
            if (irq && !p_irq) irq_rises++;
            p_irq = irq;
            if (scl_n == lvl) run++;
            else begin
                if (active && !lvl && run != exp_lo) terr++;
                if (active && lvl && seen_low && run != exp_hi) terr++;
                if (!lvl) seen_low = 1;
                lvl = scl_n;
                run = 1;
            end
            if (p_scl && scl_n && p_sda && !sda_n) begin
                starts++; active = 1; seen_low = 0;
                s_mode = 1; s_bits = 0; slv_drv = 0;
            end else if (p_scl && scl_n && !p_sda && sda_n) begin
                stops++; active = 0; s_mode = 0; slv_drv = 0;
            end else if (!p_scl && scl_n) begin
                if (s_mode == 1 && s_bits < 8) s_sh = {s_sh[6:0], sda_n};
                if (s_mode == 2 && s_bits == 8) begin
                    acks.push_back(!sda_n);
                    sent++;
                end
                if (s_mode != 0) s_bits++;
            end else if (p_scl && !scl_n) begin
                if (s_mode == 1 && s_bits == 8) begin
                    addr_seen = s_sh;
                    if (s_sh[7:1] == slave_addr && s_sh[0]) slv_drv = 1;
                    else begin s_mode = 0; slv_drv = 0; end
                end else if (s_mode == 1 && s_bits == 9) begin
                    s_mode = 2; s_bits = 0; s_idx = 0;
                    s_cur = pattern(0); slv_drv = !s_cur[7];
                end else if (s_mode == 2) begin
                    if (s_bits >= 1 && s_bits <= 7) slv_drv = !s_cur[7 - s_bits];
                    else if (s_bits == 8) slv_drv = 0;
                    else if (s_bits == 9) begin
                        if (acks[$]) begin
                            s_idx++; s_cur = pattern(s_idx); s_bits = 0;
                            slv_drv = !s_cur[7];
                        end else begin
                            s_mode = 0; slv_drv = 0;
                        end
                    end
                end
            end
            p_scl = scl_n;
            p_sda = sda_n;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic clear_model();
        acks.delete(); got.delete();
        sent = 0; starts = 0; stops = 0; irq_rises = 0; terr = 0; any_oe = 0;
        addr_seen = 0;
    endtask

    task automatic set_div(logic [15:0] d);
        reg_write(3'd2, d);
        exp_hi = (d[15:8] == 0) ? 1 : int'(d[15:8]);
        exp_lo = (d[7:0] == 0) ? 1 : int'(d[7:0]);
    endtask

    task automatic drain();
        logic [15:0] v;
        for (int n = 0; n < 4000; n++) begin
            reg_read(3'd4, v);
            if (v[3]) begin
                reg_read(3'd3, v);
                got.push_back(v[7:0]);
            end else if (!v[0]) break;
        end
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int n = 0; n < 4000; n++) begin
            reg_read(3'd4, v);
            if (!v[0]) break;
        end
    endtask

    task automatic wait_irq();
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic check_rx(string req, int n, bit [7:0] ackpat);
        check(got.size() == n, req, "bytes read", got.size(), n);
        check(sent == n, req, "bytes clocked", sent, n);
        for (int k = 0; k < n && k < got.size(); k++)
            check(got[k] == pattern(k), req, "byte value", got[k], pattern(k));
        for (int k = 0; k < n && k < acks.size(); k++)
            check(acks[k] == ackpat[k], req, "ack bit", acks[k], ackpat[k]);
    endtask

    initial begin
        logic [15:0] v;
        exp_hi = 207; exp_lo = 207;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        reg_read(3'd4, v);
        check(v == 0, "R1", "status after reset", v, 0);
        check(!irq, "R1", "irq after reset", irq, 0);
        check(!scl_oe && !sda_oe, "R1", "bus released", {scl_oe, sda_oe}, 0);

        // R2 R3 R4 R5 R6 R11: four-byte read
        set_div(16'h0302);
        clear_model();
        reg_write(3'd0, 16'd3);
        reg_write(3'd1, 16'h00A1);
        reg_read(3'd4, v);
        check(v[0], "R11", "busy during transfer", v[0], 1);
        wait_irq();
        reg_read(3'd4, v);
        check(v[3], "R6", "ready after byte", v[3], 1);
        repeat (20) @(negedge clk);
        reg_read(3'd4, v);
        check(v[3] && irq, "R6", "ready held until read", v[3], 1);
        drain();
        check_rx("R3", 4, 8'b0000_0111);
        check(addr_seen == 8'hA1, "R2", "address byte", addr_seen, 8'hA1);
        check(starts == 1 && stops == 1, "R5", "start/stop count", starts * 10 + stops, 11);
        check(terr == 0, "R4", "scl widths 3/2", terr, 0);
        reg_read(3'd4, v);
        check(v == 0, "R11", "status after stop", v, 0);

        // R3 R4 single byte, other divider
        set_div(16'h0204);
        clear_model();
        reg_write(3'd0, 16'd0);
        reg_write(3'd1, 16'h00A1);
        drain();
        check_rx("R3", 1, 8'b0000_0000);
        check(terr == 0, "R4", "scl widths 2/4", terr, 0);
        check(stops == 1, "R3", "stop after last", stops, 1);

        // R7 FIFO full
        set_div(16'h0302);
        clear_model();
        reg_write(3'd0, 16'd7);
        reg_write(3'd1, 16'h00A1);
        wait_idle();
        check(sent == 3, "R7", "bytes clocked", sent, 3);
        check(acks.size() == 3 && acks[0] && acks[1] && !acks[2], "R7", "ack pattern AAN",
              acks.size(), 3);
        reg_read(3'd4, v);
        check(v == 16'h000C, "R7", "status drop+ready", v, 16'h000C);
        reg_read(3'd3, v);
        check(v[7:0] == pattern(0), "R6", "first popped", v[7:0], pattern(0));
        reg_read(3'd4, v);
        check(v[3] && irq, "R6", "ready with one left", v[3], 1);
        reg_read(3'd3, v);
        check(v[7:0] == pattern(1), "R6", "second popped", v[7:0], pattern(1));
        reg_read(3'd4, v);
        check(!v[3] && !irq, "R6", "ready cleared by read", v[3], 0);

        // R8 address not acknowledged
        clear_model();
        slave_addr = 7'h33;
        reg_write(3'd0, 16'd2);
        reg_write(3'd1, 16'h00A1);
        wait_idle();
        reg_read(3'd4, v);
        check(v == 16'h0002, "R8", "status nack only", v, 16'h0002);
        check(sent == 0 && irq_rises == 0, "R8", "no data", sent, 0);
        check(starts == 1 && stops == 1, "R8", "start/stop", starts * 10 + stops, 11);
        slave_addr = 7'h50;

        // R9 reload mid-transfer
        clear_model();
        reg_write(3'd0, 16'd1);
        reg_write(3'd1, 16'h00A1);
        wait_irq();
        reg_read(3'd3, v);
        got.push_back(v[7:0]);
        reg_write(3'd0, 16'd2);
        reg_write(3'd1, 16'h00A1);
        drain();
        check_rx("R9", 4, 8'b0000_0111);
        check(starts == 1, "R9", "no second start", starts, 1);

        // R10 write without read bit
        clear_model();
        reg_write(3'd1, 16'h00A0);
        repeat (50) @(negedge clk);
        reg_read(3'd4, v);
        check(v == 0, "R10", "status stays idle", v, 0);
        check(!any_oe && starts == 0, "R10", "bus untouched", any_oe, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule